// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 14-bit processor virtual address into a 16-bit physical address through a four-entry segment table. The two upper address bits pick one table entry and the twelve lower bits form an offset into that segment. Each entry has four parts: a valid flag, a physical start address, a length, and a set of read, write and execute rights. A request returns either the start address plus the offset, or a fault with a cause code that names what went wrong.

Software updates the table one entry at a time through a write port. The port replaces a whole entry in one cycle. Translation has a one-cycle latency, and every accepted request produces exactly one response. When reset ends, the table holds four entries. Code sits at 0x4000 with length 0x700 and rights read and execute. Data sits at 0x0000 with length 0x500 and rights read and write. The heap entry is not valid. Stack sits at 0x2000 with length 0x1000 and rights read and write.

Top module: `seg_xlat`

## Requirements
- R1: While reset is high, and in the first cycle after it, rsp_valid is 0. After reset, the table holds the boot contents listed above. Segment numbers are 0 code, 1 data, 2 heap, 3 stack.
- R2: The segment number is req_vaddr[13:12] and the offset is req_vaddr[11:0]. A response for a request accepted at clock edge N appears after edge N. rsp_valid is high for exactly one cycle per request and low in every other cycle.
- R3: A request that does not fault returns rsp_fault=0, rsp_cause=0 and rsp_paddr = base + offset, taken modulo 2^16.
- R4: A request to an entry whose valid flag is 0 faults with cause 1 (invalid segment). The offset and the request kind do not matter.
- R5: A request to a valid entry whose offset is greater than or equal to the entry length faults with cause 2 (bound). A length of 0 makes every offset fault. A length of 0x1000 makes no offset fault.
- R6: Request kinds are encoded as 0 read, 1 write, 2 execute, 3 reserved. A request within bounds whose kind lacks the needed right faults with cause 3 (permission). Kind 3 always lacks the needed right. Rights are encoded as tbl_perm bit 0 read, bit 1 write, bit 2 execute.
- R7: When one request has more than one problem, the block reports the single cause with the highest priority. An invalid segment ranks above a bound fault, and a bound fault ranks above a permission fault.
- R8: A table write in cycle N changes only the indexed entry. A request in cycle N still sees the old entry, and requests from cycle N+1 onward see the new entry.
- R9: On a fault, rsp_paddr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 14 | Virtual address: segment number in the top 2 bits, offset in the low 12 |
| req_kind | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 reserved |
| tbl_we | input | 1 | Table entry write strobe |
| tbl_idx | input | 2 | Index of the entry to write |
| tbl_valid | input | 1 | Valid flag to write |
| tbl_base | input | 16 | Physical start address to write |
| tbl_len | input | 13 | Segment length to write (0 to 0x1000) |
| tbl_perm | input | 3 | Rights to write: bit 0 read, bit 1 write, bit 2 execute |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Translated physical address, 0 on a fault |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 2 | 0 none, 1 invalid segment, 2 bound, 3 permission |

## Verification
A wrong table entry is visible on the first request that reaches it after the write, one cycle later. It shows up as a wrong physical address, a wrong fault decision or a wrong cause code. A write that lands on the wrong index, or one that takes effect a cycle early, changes the answer for the request made in the write cycle or for a request to some other segment. The same-cycle and neighbour checks catch both cases right away. A wrong comparison at the bound shows only at offsets equal to the length or one below it, so the bench probes those exact offsets as well as the lengths 0 and 0x1000.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    localparam int SEG_BITS = 2;
    localparam int OFF_BITS = 12;
    localparam int VA_BITS  = SEG_BITS + OFF_BITS;
    localparam int PA_BITS  = 16;
    localparam int LEN_BITS = OFF_BITS + 1;
    localparam int NUM_SEGS = 1 << SEG_BITS;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_BOUND   = 2'd2,
        CAUSE_PERM    = 2'd3
    } fault_cause_e;

    // bit 2 execute, bit 1 write, bit 0 read
    typedef struct packed {
        logic x;
        logic w;
        logic r;
    } rights_t;

    typedef struct packed {
        logic                valid;
        logic [PA_BITS-1:0]  base;
        logic [LEN_BITS-1:0] len;
        rights_t             rights;
    } seg_entry_t;

    function automatic seg_entry_t boot_entry(input int idx);
        seg_entry_t e;
        e = '0;
        case (idx)
            0: begin e.valid = 1'b1; e.base = 16'h4000; e.len = 13'h0700; e.rights = '{x:1'b1, w:1'b0, r:1'b1}; end
            1: begin e.valid = 1'b1; e.base = 16'h0000; e.len = 13'h0500; e.rights = '{x:1'b0, w:1'b1, r:1'b1}; end
            3: begin e.valid = 1'b1; e.base = 16'h2000; e.len = 13'h1000; e.rights = '{x:1'b0, w:1'b1, r:1'b1}; end
            default: e = '0;
        endcase
        return e;
    endfunction

    function automatic logic right_granted(input rights_t rt, input acc_kind_e kind);
        case (kind)
            ACC_READ:  return rt.r;
            ACC_WRITE: return rt.w;
            ACC_EXEC:  return rt.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SEG_BITS-1:0] wr_idx,
    input  seg_entry_t          wr_entry,
    input  logic [SEG_BITS-1:0] rd_idx,
    output seg_entry_t          rd_entry
);

    seg_entry_t entries_q [NUM_SEGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                entries_q[i] <= boot_entry(i);
            end
        end else if (wr_en) begin
            entries_q[wr_idx] <= wr_entry;
        end
    end

    assign rd_entry = entries_q[rd_idx];

    // R8
    write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (entries_q[$past(wr_idx)] == $past(wr_entry)));

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
(
    input  seg_entry_t          entry,
    input  logic [OFF_BITS-1:0] offset,
    input  acc_kind_e           kind,
    output fault_cause_e        cause,
    output logic [PA_BITS-1:0]  paddr
);

    logic in_bound;
    logic allowed;

    assign in_bound = {1'b0, offset} < entry.len;
    assign allowed  = right_granted(entry.rights, kind);

    always_comb begin
        if (!entry.valid)   cause = CAUSE_INVALID;
        else if (!in_bound) cause = CAUSE_BOUND;
        else if (!allowed)  cause = CAUSE_PERM;
        else                cause = CAUSE_NONE;
    end

    assign paddr = (cause == CAUSE_NONE)
                 ? entry.base + PA_BITS'(offset)
                 : '0;

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [13:0] req_vaddr,
    input  logic [1:0]  req_kind,
    input  logic        tbl_we,
    input  logic [1:0]  tbl_idx,
    input  logic        tbl_valid,
    input  logic [15:0] tbl_base,
    input  logic [12:0] tbl_len,
    input  logic [2:0]  tbl_perm,
    output logic        rsp_valid,
    output logic [15:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [1:0]  rsp_cause
);

    seg_entry_t          wr_entry;
    seg_entry_t          cur_entry;
    logic [SEG_BITS-1:0] seg_num;
    logic [OFF_BITS-1:0] offset;
    fault_cause_e        cause_d;
    logic [PA_BITS-1:0]  paddr_d;

    assign seg_num = req_vaddr[VA_BITS-1:OFF_BITS];
    assign offset  = req_vaddr[OFF_BITS-1:0];

    always_comb begin
        wr_entry        = '0;
        wr_entry.valid  = tbl_valid;
        wr_entry.base   = tbl_base;
        wr_entry.len    = tbl_len;
        wr_entry.rights = rights_t'(tbl_perm);
    end

    seg_table table_i (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (tbl_we),
        .wr_idx   (tbl_idx),
        .wr_entry (wr_entry),
        .rd_idx   (seg_num),
        .rd_entry (cur_entry)
    );

    seg_check check_i (
        .entry  (cur_entry),
        .offset (offset),
        .kind   (acc_kind_e'(req_kind)),
        .cause  (cause_d),
        .paddr  (paddr_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_paddr <= '0;
            rsp_fault <= 1'b0;
            rsp_cause <= CAUSE_NONE;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_paddr <= paddr_d;
                rsp_fault <= (cause_d != CAUSE_NONE);
                rsp_cause <= cause_d;
            end
        end
    end

    // R2
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R4
    invalid_seg_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !cur_entry.valid) |=> (rsp_fault && rsp_cause == CAUSE_INVALID));

    // R9
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_cause != CAUSE_NONE));

endmodule

// File: tb/seg_xlat_tb_top.sv
module seg_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [13:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        tbl_we;
    logic [1:0]  tbl_idx;
    logic        tbl_valid;
    logic [15:0] tbl_base;
    logic [12:0] tbl_len;
    logic [2:0]  tbl_perm;
    logic        rsp_valid;
    logic [15:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        m_valid [4];
    logic [15:0] m_base  [4];
    logic [12:0] m_len   [4];
    logic [2:0]  m_perm  [4];

    always #5 clk = ~clk;

    seg_xlat dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_valid(tbl_valid), .tbl_base(tbl_base), .tbl_len(tbl_len),
        .tbl_perm(tbl_perm), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
        .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
    );

    function automatic logic [1:0] exp_cause(input logic [13:0] va, input logic [1:0] kind);
        int s;
        logic [11:0] off;
        logic need;
        s   = int'(va[13:12]);
        off = va[11:0];
        if (!m_valid[s]) return 2'd1;
        if ({1'b0, off} >= m_len[s]) return 2'd2;
        case (kind)
            2'd0: need = m_perm[s][0];
            2'd1: need = m_perm[s][1];
            2'd2: need = m_perm[s][2];
            default: need = 1'b0;
        endcase
        return need ? 2'd0 : 2'd3;
    endfunction

    function automatic logic [15:0] exp_paddr(input logic [13:0] va, input logic [1:0] kind);
        if (exp_cause(va, kind) != 2'd0) return 16'h0;
        return m_base[int'(va[13:12])] + {4'h0, va[11:0]};
    endfunction

    task automatic model_boot();
        m_valid[0] = 1; m_base[0] = 16'h4000; m_len[0] = 13'h0700; m_perm[0] = 3'b101;
        m_valid[1] = 1; m_base[1] = 16'h0000; m_len[1] = 13'h0500; m_perm[1] = 3'b011;
        m_valid[2] = 0; m_base[2] = 16'h0000; m_len[2] = 13'h0000; m_perm[2] = 3'b000;
        m_valid[3] = 1; m_base[3] = 16'h2000; m_len[3] = 13'h1000; m_perm[3] = 3'b011;
    endtask

    task automatic check_rsp(input string req, input logic [15:0] ep, input logic [1:0] ec);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_paddr !== ep || rsp_cause !== ec || rsp_fault !== (ec != 2'd0)) begin
            errors++;
            $display("FAIL %s: got valid=%0b paddr=%h fault=%0b cause=%0d, expected valid=1 paddr=%h fault=%0b cause=%0d",
                     req, rsp_valid, rsp_paddr, rsp_fault, rsp_cause, ep, (ec != 2'd0), ec);
        end
    endtask

    task automatic do_req(input string req, input logic [13:0] va, input logic [1:0] kind);
        logic [15:0] ep;
        logic [1:0]  ec;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_kind = kind;
        ep = exp_paddr(va, kind);
        ec = exp_cause(va, kind);
        @(negedge clk);
        req_valid = 0;
        check_rsp(req, ep, ec);
    endtask

    task automatic do_write(input logic [1:0] idx, input logic v, input logic [15:0] b,
                            input logic [12:0] l, input logic [2:0] p);
        @(negedge clk);
        tbl_we = 1; tbl_idx = idx; tbl_valid = v; tbl_base = b; tbl_len = l; tbl_perm = p;
        @(negedge clk);
        tbl_we = 0;
        m_valid[idx] = v; m_base[idx] = b; m_len[idx] = l; m_perm[idx] = p;
    endtask

    initial begin
        #1_500_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] ep;
        logic [1:0]  ec;
        void'($urandom(32'h5eed_1234));
        rst = 1; req_valid = 0; req_vaddr = '0; req_kind = '0;
        tbl_we = 0; tbl_idx = '0; tbl_valid = 0; tbl_base = '0; tbl_len = '0; tbl_perm = '0;
        model_boot();
        repeat (3) @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got rsp_valid=%0b expected 0", rsp_valid);
        end
        rst = 0;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 after reset: got rsp_valid=%0b expected 0", rsp_valid);
        end

        // R1, R3: boot table translations
        do_req("R1 R3 code read start",   14'h0000, 2'd0);
        do_req("R3 code exec last",       14'h06FF, 2'd2);
        do_req("R3 data write",           14'h1123, 2'd1);
        do_req("R3 stack write top",      14'h3FFF, 2'd1);
        // R5 bound edges
        do_req("R5 code at length",       14'h0700, 2'd0);
        do_req("R5 data at length",       14'h1500, 2'd1);
        do_req("R5 data one below",       14'h14FF, 2'd0);
        // R4 invalid heap
        do_req("R4 heap read",            14'h2000, 2'd0);
        do_req("R4 heap exec",            14'h2FFF, 2'd2);
        // R6 permissions
        do_req("R6 code write",           14'h0010, 2'd1);
        do_req("R6 data exec",            14'h1010, 2'd2);
        do_req("R6 reserved kind",        14'h3000, 2'd3);
        // R7 priority: bound over permission
        do_req("R7 code write beyond",    14'h0800, 2'd1);

        // R2: idle cycle gives no response
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 idle: got rsp_valid=%0b expected 0", rsp_valid);
        end

        // R8: same-cycle write and request uses old entry; R7 invalid over bound
        @(negedge clk);
        tbl_we = 1; tbl_idx = 2'd2; tbl_valid = 1; tbl_base = 16'h8000; tbl_len = 13'h0100; tbl_perm = 3'b111;
        req_valid = 1; req_vaddr = 14'h2050; req_kind = 2'd0;
        ep = exp_paddr(14'h2050, 2'd0);
        ec = exp_cause(14'h2050, 2'd0);
        @(negedge clk);
        tbl_we = 0; req_valid = 0;
        check_rsp("R8 same-cycle old entry", ep, ec);
        m_valid[2] = 1; m_base[2] = 16'h8000; m_len[2] = 13'h0100; m_perm[2] = 3'b111;
        do_req("R8 next cycle new entry", 14'h2050, 2'd2);
        do_req("R5 R8 new bound",         14'h2100, 2'd0);
        do_req("R8 neighbour untouched",  14'h3050, 2'd0);

        // R5 length 0 and wrap of R3
        do_write(2'd1, 1, 16'hFFF0, 13'h0000, 3'b111);
        do_req("R5 zero length",          14'h1000, 2'd0);
        do_write(2'd1, 1, 16'hFFF0, 13'h1000, 3'b111);
        do_req("R3 wrap",                 14'h1020, 2'd1);
        // R7 invalid over permission
        do_write(2'd0, 0, 16'h1234, 13'h1000, 3'b000);
        do_req("R7 invalid over perm",    14'h0001, 2'd1);

        // random mix: R3 R4 R5 R6 R8
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0) begin
                logic [12:0] l;
                case ($urandom_range(0, 3))
                    0: l = 13'h0000;
                    1: l = 13'h1000;
                    default: l = 13'($urandom_range(0, 4096));
                endcase
                do_write(2'($urandom_range(0, 3)), 1'($urandom_range(0, 4) != 0),
                         16'($urandom), l, 3'($urandom));
            end else begin
                do_req("R3 R4 R5 R6 random", 14'($urandom), 2'($urandom_range(0, 3)));
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule